// File: doc/BRIEF.md
# Segmented Address Generator and Region Decoder

This block turns a real-mode style segment:offset pair into a physical byte address and tells the rest of the chip which part of the address map that address falls in. Both operands are 16 bits wide. The physical address is the segment shifted left by four bit positions, plus the offset. Because the two operands overlap in twelve bit positions, many different pairs name the same byte.

A gate input selects the width of the result. With the gate closed, any carry out of bit 19 is dropped, so high addresses wrap back to the bottom of a 1 MiB space. With the gate open, all 24 bits are kept, which reaches a little past the first megabyte.

Each request is also marked as either a memory cycle or a port cycle. A memory cycle is classified into one of three regions: the low 640 KiB of ordinary memory, the 384 KiB device window above it, or memory above 1 MiB. A port cycle bypasses the map. It puts its 16-bit port number on the address bus and raises only the port select. Results are registered and appear on the cycle after a request is taken. Out of reset, the block presents the power-on fetch location.

Top module: `seg_addr_unit`

## Requirements
- R1: With the gate open and a memory cycle, `phys_addr` equals `seg_in`×16 + `ofs_in` using full 24-bit arithmetic. 1234:5678 and 179B:0008 both give 0179B8h.
- R2: With the gate closed, bits 23:20 of `phys_addr` are zero and bits 19:0 are the low 20 bits of the sum. FF00:1000 gives 000000h.
- R3: With the gate open, the carry into bit 20 is kept. FF00:1000 gives 100000h, and FFFF:FFFF gives 10FFEFh.
- R4: A memory address in 000000h to 09FFFFh raises `sel_conv` only.
- R5: A memory address in 0A0000h to 0FFFFFh raises `sel_dev` only.
- R6: A memory address of 100000h or above raises `sel_high` only.
- R7: When `port_cyc`=1, `phys_addr` is {8'h00, `ofs_in`} and only `sel_port` is raised. `seg_in` and `wide_en` have no effect on the result.
- R8: Exactly one of `sel_conv`, `sel_dev`, `sel_high` and `sel_port` is high at all times.
- R9: A request is accepted at a rising edge when `in_valid`=1. Its result is visible after that same edge, and `out_valid` is high for exactly that cycle. When `in_valid`=0, `out_valid` goes low and the address and selects hold their values.
- R10: Reset sets `out_valid`=0 and `phys_addr` to 0FFFF0h, the power-on fetch location FFFF:0000. Because that address lies in the device window, reset also raises `sel_dev`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Request strobe; the inputs below are taken when this is high |
| seg_in | input | 16 | Segment operand |
| ofs_in | input | 16 | Offset operand; also the port number in a port cycle |
| wide_en | input | 1 | Gate: 1 keeps 24 address bits, 0 wraps at 20 bits |
| port_cyc | input | 1 | Status input: 1 marks a port cycle, 0 a memory cycle |
| out_valid | output | 1 | High for one cycle when a new result is shown |
| phys_addr | output | 24 | Registered physical address or port number |
| sel_conv | output | 1 | Region select: conventional memory |
| sel_dev | output | 1 | Region select: reserved device window |
| sel_high | output | 1 | Region select: memory above 1 MiB |
| sel_port | output | 1 | Select: I/O port space |

## Verification
Directed pairs that alias to the same byte show whether the shift and the add line up. A pair with a carry out of bit 19 is applied with the gate both closed and open, which shows whether the gate really drops that carry. Addresses placed on each side of 0A0000h and 100000h show whether the region comparisons are off by one. Random pairs, mixed across gate settings and cycle types, are compared with a bench model. Idle cycles between requests show that results hold.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;

  // One-hot region code; bit order matches the select outputs
  typedef enum logic [3:0] {
    RG_CONV = 4'b0001,
    RG_DEV  = 4'b0010,
    RG_HIGH = 4'b0100,
    RG_PORT = 4'b1000
  } region_e;

endpackage

// File: rtl/seg_rst_sync.sv
module seg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/seg_addr_calc.sv
module seg_addr_calc #(
  parameter int SEG_W  = 16,
  parameter int OFS_W  = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 24,
  parameter int WRAP_W = 20
) (
  input  logic [SEG_W-1:0]  seg_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              gate_open_i,
  output logic [ADDR_W-1:0] addr_o
);

  localparam int BASE_W = SEG_W + SHIFT;
  localparam int SUM_W  = ((BASE_W > OFS_W) ? BASE_W : OFS_W) + 1;
  localparam logic [ADDR_W-1:0] WRAP_MASK =
    {{(ADDR_W-WRAP_W){1'b0}}, {WRAP_W{1'b1}}};

  logic [SUM_W-1:0]  sum_w;
  logic [ADDR_W-1:0] full_w;

  // Segment scaled by 2**SHIFT, offset zero-extended, one carry bit spare
  assign sum_w  = SUM_W'({seg_i, {SHIFT{1'b0}}}) + SUM_W'(ofs_i);
  assign full_w = ADDR_W'(sum_w);

  // Closed gate discards everything from bit WRAP_W upward
  assign addr_o = gate_open_i ? full_w : (full_w & WRAP_MASK);

endmodule

// File: rtl/seg_region_dec.sv
module seg_region_dec
  import seg_addr_pkg::*;
#(
  parameter int                 ADDR_W    = 24,
  parameter logic [ADDR_W-1:0]  CONV_END  = 24'h0A0000,
  parameter logic [ADDR_W-1:0]  HIGH_BASE = 24'h100000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output region_e           region_o
);

  always_comb begin
    if (addr_i < CONV_END)       region_o = RG_CONV;
    else if (addr_i < HIGH_BASE) region_o = RG_DEV;
    else                         region_o = RG_HIGH;
  end

endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
#(
  parameter int          SEG_W    = 16,
  parameter int          OFS_W    = 16,
  parameter int          SHIFT    = 4,
  parameter int          ADDR_W   = 24,
  parameter int          WRAP_W   = 20,
  parameter int          SYNC_STG = 2,
  parameter logic [15:0] RST_SEG  = 16'hFFFF,
  parameter logic [15:0] RST_OFS  = 16'h0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [SEG_W-1:0]  seg_in,
  input  logic [OFS_W-1:0]  ofs_in,
  input  logic              wide_en,
  input  logic              port_cyc,
  output logic              out_valid,
  output logic [ADDR_W-1:0] phys_addr,
  output logic              sel_conv,
  output logic              sel_dev,
  output logic              sel_high,
  output logic              sel_port
);

  localparam logic [ADDR_W-1:0] RESET_ADDR =
    (ADDR_W'(RST_SEG) << SHIFT) + ADDR_W'(RST_OFS);
  localparam logic [ADDR_W-1:0] CONV_END   = ADDR_W'(24'h0A0000);
  localparam logic [ADDR_W-1:0] HIGH_BASE  = ADDR_W'(1) << WRAP_W;

  logic              rst_n_s;
  logic [ADDR_W-1:0] mem_addr;
  region_e           mem_region;

  logic [ADDR_W-1:0] addr_d, addr_q;
  region_e           region_d, region_q;
  logic              valid_q;

  seg_rst_sync #(.STAGES(SYNC_STG)) u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  seg_addr_calc #(
    .SEG_W (SEG_W), .OFS_W (OFS_W), .SHIFT (SHIFT),
    .ADDR_W(ADDR_W), .WRAP_W(WRAP_W)
  ) u_calc (
    .seg_i       (seg_in),
    .ofs_i       (ofs_in),
    .gate_open_i (wide_en),
    .addr_o      (mem_addr)
  );

  seg_region_dec #(
    .ADDR_W(ADDR_W), .CONV_END(CONV_END), .HIGH_BASE(HIGH_BASE)
  ) u_dec (
    .addr_i   (mem_addr),
    .region_o (mem_region)
  );

  // Next state: port cycles bypass the memory map entirely
  always_comb begin
    if (port_cyc) begin
      addr_d   = ADDR_W'(ofs_in);
      region_d = RG_PORT;
    end else begin
      addr_d   = mem_addr;
      region_d = mem_region;
    end
  end

  // Registers with explicit clock enable on the data path
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      valid_q  <= 1'b0;
      addr_q   <= RESET_ADDR;
      region_q <= RG_DEV;
    end else begin
      valid_q <= in_valid;
      if (in_valid) begin
        addr_q   <= addr_d;
        region_q <= region_d;
      end
    end
  end

  assign out_valid = valid_q;
  assign phys_addr = addr_q;
  assign sel_conv  = region_q[0];
  assign sel_dev   = region_q[1];
  assign sel_high  = region_q[2];
  assign sel_port  = region_q[3];

endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [15:0] seg_in,
  input logic [15:0] ofs_in,
  input logic        wide_en,
  input logic        port_cyc,
  input logic        out_valid,
  input logic [23:0] phys_addr,
  input logic        sel_conv,
  input logic        sel_dev,
  input logic        sel_high,
  input logic        sel_port
);

  a_r8_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({sel_conv, sel_dev, sel_high, sel_port}) == 1);

  a_r2_wrap_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !wide_en && !port_cyc) |=> (phys_addr[23:20] == 4'h0));

  a_r7_port_path: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && port_cyc) |=>
      (sel_port && phys_addr == {8'h00, $past(ofs_in)}));

  a_r9_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(phys_addr) && $stable(sel_conv)
                   && $stable(sel_dev) && $stable(sel_high)));

  a_r4_conv_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_conv |-> (phys_addr < 24'h0A0000));

  a_r6_high_range: assert property (@(posedge clk) disable iff (!rst_n)
    sel_high |-> (phys_addr >= 24'h100000));

endmodule

bind seg_addr_unit seg_addr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_in(seg_in),
  .ofs_in(ofs_in), .wide_en(wide_en), .port_cyc(port_cyc),
  .out_valid(out_valid), .phys_addr(phys_addr), .sel_conv(sel_conv),
  .sel_dev(sel_dev), .sel_high(sel_high), .sel_port(sel_port)
);

// File: tb/sim_seg_addr_unit.sv
`timescale 1ns/1ps
module sim_seg_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] seg_in = '0;
  logic [15:0] ofs_in = '0;
  logic        wide_en = 1'b0;
  logic        port_cyc = 1'b0;
  logic        out_valid;
  logic [23:0] phys_addr;
  logic        sel_conv, sel_dev, sel_high, sel_port;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  seg_addr_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .seg_in(seg_in),
    .ofs_in(ofs_in), .wide_en(wide_en), .port_cyc(port_cyc),
    .out_valid(out_valid), .phys_addr(phys_addr), .sel_conv(sel_conv),
    .sel_dev(sel_dev), .sel_high(sel_high), .sel_port(sel_port)
  );

  function automatic logic [23:0] model_addr(logic [15:0] s, logic [15:0] o,
                                             logic w, logic p);
    logic [23:0] a;
    if (p) return {8'h00, o};
    a = {4'h0, s, 4'h0} + {8'h00, o};
    if (!w) a[23:20] = 4'h0;
    return a;
  endfunction

  // Select vector order: {port, high, dev, conv}
  function automatic logic [3:0] model_sel(logic [23:0] a, logic p);
    if (p)                return 4'b1000;
    if (a < 24'h0A0000)   return 4'b0001;
    if (a < 24'h100000)   return 4'b0010;
    return 4'b0100;
  endfunction

  function automatic string req_of(logic [3:0] s, logic w);
    if (s[3]) return "R7";
    if (s[2]) return "R6";
    if (s[1]) return "R5";
    return w ? "R4/R3" : "R4/R2";
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(logic [15:0] s, logic [15:0] o, logic w, logic p,
                       string req);
    logic [23:0] ea;
    logic [3:0]  es;
    ea = model_addr(s, o, w, p);
    es = model_sel(ea, p);
    @(negedge clk);
    seg_in = s; ofs_in = o; wide_en = w; port_cyc = p; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " R9 valid"}, {31'b0, out_valid}, 32'd1);
    check({req, " addr"}, {8'h0, phys_addr}, {8'h0, ea});
    check({req, " select"}, {28'h0, sel_port, sel_high, sel_dev, sel_conv},
          {28'h0, es});
    // Idle cycle with scrambled inputs: result must hold
    seg_in = ~s; ofs_in = ~o; wide_en = ~w; port_cyc = ~p;
    @(negedge clk);
    check("R9 idle hold", {7'h0, out_valid, phys_addr}, {8'h0, ea});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] rs, ro;
    logic        rw, rp;
    logic [31:0] seed;
    seed = 32'd20240611;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10 reset state
    check("R10 valid", {31'b0, out_valid}, 32'd0);
    check("R10 addr", {8'h0, phys_addr}, 32'h000FFFF0);
    check("R10 select", {28'h0, sel_port, sel_high, sel_dev, sel_conv}, 32'h2);

    // R1 aliasing pairs
    apply(16'h1234, 16'h5678, 1'b1, 1'b0, "R1");
    check("R1 alias 1234:5678", {8'h0, phys_addr}, 32'h000179B8);
    apply(16'h179B, 16'h0008, 1'b1, 1'b0, "R1");
    check("R1 alias 179B:0008", {8'h0, phys_addr}, 32'h000179B8);
    apply(16'h1234, 16'h5678, 1'b0, 1'b0, "R2");
    // R2 / R3 wrap gate
    apply(16'hFF00, 16'h1000, 1'b0, 1'b0, "R2");
    check("R2 FF00:1000 wraps", {8'h0, phys_addr}, 32'h0);
    apply(16'hFF00, 16'h1000, 1'b1, 1'b0, "R3");
    check("R3 FF00:1000 wide", {8'h0, phys_addr}, 32'h00100000);
    apply(16'hFFFF, 16'hFFFF, 1'b1, 1'b0, "R3");
    check("R3 top address", {8'h0, phys_addr}, 32'h0010FFEF);
    apply(16'hFFFF, 16'hFFFF, 1'b0, 1'b0, "R2");
    // R4/R5/R6 boundaries
    apply(16'h9000, 16'hFFFF, 1'b0, 1'b0, "R4");
    apply(16'hA000, 16'h0000, 1'b0, 1'b0, "R5");
    apply(16'hF000, 16'hFFFF, 1'b1, 1'b0, "R5");
    apply(16'hF001, 16'hFFF0, 1'b1, 1'b0, "R6");
    // R7 port cycles ignore segment and gate
    apply(16'hFFFF, 16'h03F8, 1'b1, 1'b1, "R7");
    apply(16'h0000, 16'hFFFF, 1'b0, 1'b1, "R7");

    for (int i = 0; i < 400; i++) begin
      rs = 16'($urandom); ro = 16'($urandom);
      rw = 1'($urandom); rp = (($urandom % 8) == 0);
      apply(rs, ro, rw, rp,
            req_of(model_sel(model_addr(rs, ro, rw, rp), rp), rw));
      // R8: exactly one select
      check("R8 one select",
            $countones({sel_port, sel_high, sel_dev, sel_conv}), 32'd1);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule